// File: doc/BRIEF.md
# Smart Card Transmit-End Flag Generator

This block produces the transmit-end status flag of a smart card style serial transmitter. A value of 0 means a character is still on its way out; a value of 1 means the transmitter has gone quiet. The transmitter calls the flag "ended" only after a guard interval measured in elementary time units (etu) has passed since the last character. That interval is 2.5, 1.5 or 1.0 etu, and two mode inputs choose it. A flag set is withheld while the line carries an error signal from the receiving card.

The surrounding transmitter supplies four things. It marks the end of each serialized character with a one-cycle pulse. It sends a tick every half etu. It provides the current data-empty flag, the error-signal status and the transmit enable. It also reports the register accesses that clear the flag: a read of the data-empty flag, a write of 0 to that flag, and a data-register refill by a DMA transfer. The guard interval is counted in half-etu ticks, so the three intervals are 5, 3 and 2 ticks.

Top module: `sctx_end_flag`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_end_o` is 1.
- R2: When `low_power_i` is 1, `tx_end_o` is 1 in the next cycle, whatever the other inputs are.
- R3: When `tx_en_i` is 0 and `err_sig_i` is 0, `tx_end_o` is 1 in the next cycle. When `tx_en_i` is 0 and `err_sig_i` is 1, the flag holds its value.
- R4: With `gsm_i`=0 and `blk_i`=0, `tx_end_o` rises in the cycle after the clock edge that samples the 5th half-etu tick following `char_done_i`, provided `empty_i`=1 and `err_sig_i`=0 at that edge. After the 4th tick it is still 0.
- R5: With `gsm_i`=0 and `blk_i`=1, the flag rises after the 3rd tick in the same way, and not after the 2nd.
- R6: With `gsm_i`=1, the flag rises after the 2nd tick, whether `blk_i` is 0 or 1.
- R7: A `empty_wr0_i` pulse clears `tx_end_o` in the next cycle if an `empty_rd_i` pulse sampled while `empty_i`=1 has come before it, with no other write of 0 between the two.
- R8: A `dma_fill_i` pulse clears `tx_end_o` in the next cycle.
- R9: A `empty_wr0_i` pulse that has no qualifying read before it leaves `tx_end_o` unchanged. A read sampled while `empty_i`=0 does not qualify.
- R10: If `err_sig_i` is 1 during a guard count, the pending set is cancelled. Later ticks do not raise the flag, and it does not rise while `err_sig_i` is 1.
- R11: A refill (`dma_fill_i` or a qualified write of 0) during a guard count cancels the pending set.
- R12: If the count completes while `empty_i`=0, the flag stays 0.
- R13: A half-etu tick that arrives in the same cycle as `char_done_i` is not counted. The count restarts from that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_power_i | input | 1 | Standby or module-stop state; forces the flag to 1 |
| tx_en_i | input | 1 | Transmit enable |
| err_sig_i | input | 1 | Error-signal status from the receiver side |
| gsm_i | input | 1 | Short guard mode (1.0 etu) |
| blk_i | input | 1 | Block transfer mode (1.5 etu when gsm_i=0) |
| char_done_i | input | 1 | One-cycle pulse at the end of a serialized character |
| half_tick_i | input | 1 | One-cycle pulse every half etu |
| empty_i | input | 1 | Current data-empty flag |
| empty_rd_i | input | 1 | Software read of the data-empty flag |
| empty_wr0_i | input | 1 | Software write of 0 to the data-empty flag |
| dma_fill_i | input | 1 | DMA write of new data into the data register |
| tx_end_o | output | 1 | Transmit-end flag: 1 = ended, 0 = in progress |

## Verification
A wrong guard-counter value shows at the port as a flag edge one or more half-etu ticks early or late. That fault is visible within at most 5 ticks of a character end. A stale read-qualification bit shows on the next write of 0, where the flag either clears when it should hold or holds when it should clear. A timer that misses an abort shows as a flag rise while an error signal is present, or after a refill, at the tick where the cancelled count would have ended.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

    // Width of the half-etu guard counter
    parameter int unsigned CNT_W = 4;

    typedef logic [CNT_W-1:0] gcnt_t;

    typedef struct packed {
        logic  active;
        gcnt_t cnt;
    } gtimer_st_t;

    typedef struct packed {
        logic armed;
    } arm_st_t;

    typedef struct packed {
        logic flag;
    } flag_st_t;

endpackage

// File: rtl/sctx_guard_sel.sv
module sctx_guard_sel
    import sctx_pkg::*;
#(
    parameter int unsigned TICKS_NORM = 5,
    parameter int unsigned TICKS_BLK  = 3,
    parameter int unsigned TICKS_GSM  = 2
) (
    input  logic  gsm_i,
    input  logic  blk_i,
    output gcnt_t load_o
);
    localparam int unsigned MAX_TICKS = (1 << CNT_W) - 1;

    generate
        if (TICKS_NORM > MAX_TICKS || TICKS_BLK > MAX_TICKS || TICKS_GSM > MAX_TICKS ||
            TICKS_NORM == 0 || TICKS_BLK == 0 || TICKS_GSM == 0) begin : g_bad
            initial $error("guard tick counts must be 1..%0d", MAX_TICKS);
        end
    endgenerate

    // Short guard wins over block mode
    always_comb begin
        if (gsm_i)      load_o = gcnt_t'(TICKS_GSM);
        else if (blk_i) load_o = gcnt_t'(TICKS_BLK);
        else            load_o = gcnt_t'(TICKS_NORM);
    end
endmodule

// File: rtl/sctx_guard_timer.sv
module sctx_guard_timer
    import sctx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  tick_i,
    input  logic  abort_i,
    input  gcnt_t load_i,
    output logic  done_o,
    output logic  busy_o
);
    gtimer_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (abort_i) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (start_i) begin
            // Start pulse restarts the count; a tick in the same cycle is dropped
            st_d.active = 1'b1;
            st_d.cnt    = load_i;
        end else if (st_q.active && tick_i) begin
            if (st_q.cnt == gcnt_t'(1)) begin
                done_o      = 1'b1;
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt - gcnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.active;
endmodule

// File: rtl/sctx_rd_qual.sv
module sctx_rd_qual
    import sctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic wr0_i,
    input  logic empty_i,
    output logic clr_o
);
    arm_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = wr0_i && st_q.armed;
        if (wr0_i)                st_d.armed = 1'b0;
        else if (rd_i && empty_i) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sctx_end_flag.sv
module sctx_end_flag
    import sctx_pkg::*;
#(
    parameter int unsigned TICKS_NORM = 5,
    parameter int unsigned TICKS_BLK  = 3,
    parameter int unsigned TICKS_GSM  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_power_i,
    input  logic tx_en_i,
    input  logic err_sig_i,
    input  logic gsm_i,
    input  logic blk_i,
    input  logic char_done_i,
    input  logic half_tick_i,
    input  logic empty_i,
    input  logic empty_rd_i,
    input  logic empty_wr0_i,
    input  logic dma_fill_i,
    output logic tx_end_o
);
    gcnt_t    load_w;
    logic     sw_clr_w, done_w, busy_w, refill_w, abort_w, idle_w;
    flag_st_t st_d, st_q;

    sctx_guard_sel #(
        .TICKS_NORM(TICKS_NORM),
        .TICKS_BLK (TICKS_BLK),
        .TICKS_GSM (TICKS_GSM)
    ) u_sel (
        .gsm_i (gsm_i),
        .blk_i (blk_i),
        .load_o(load_w)
    );

    sctx_rd_qual u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (empty_rd_i),
        .wr0_i  (empty_wr0_i),
        .empty_i(empty_i),
        .clr_o  (sw_clr_w)
    );

    assign refill_w = sw_clr_w || dma_fill_i;
    assign idle_w   = !tx_en_i && !err_sig_i;
    assign abort_w  = refill_w || err_sig_i || low_power_i || !tx_en_i;

    sctx_guard_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(char_done_i),
        .tick_i (half_tick_i),
        .abort_i(abort_w),
        .load_i (load_w),
        .done_o (done_w),
        .busy_o (busy_w)
    );

    always_comb begin
        st_d = st_q;
        if (low_power_i)                      st_d.flag = 1'b1;
        else if (idle_w)                      st_d.flag = 1'b1;
        else if (refill_w)                    st_d.flag = 1'b0;
        else if (done_w && empty_i && !err_sig_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b1};
        else        st_q <= st_d;
    end

    assign tx_end_o = st_q.flag;
endmodule

// File: rtl/sctx_end_flag_chk.sv
module sctx_end_flag_chk (
    input logic clk,
    input logic rst_n,
    input logic low_power_i,
    input logic tx_en_i,
    input logic err_sig_i,
    input logic half_tick_i,
    input logic dma_fill_i,
    input logic tx_end_o
);
    // R1
    always @(negedge clk) if (!rst_n) reset_val_chk: assert (tx_end_o === 1'b1);

    // R2
    low_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_power_i |=> tx_end_o);

    // R3
    idle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_i && !err_sig_i) |=> tx_end_o);

    // R8
    dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_fill_i && tx_en_i && !low_power_i) |=> !tx_end_o);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_end_o && err_sig_i && !low_power_i) |=> !tx_end_o);

    // R4
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end_o) |-> $past(low_power_i || (!tx_en_i && !err_sig_i) || half_tick_i));
endmodule

bind sctx_end_flag sctx_end_flag_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .low_power_i(low_power_i),
    .tx_en_i    (tx_en_i),
    .err_sig_i  (err_sig_i),
    .half_tick_i(half_tick_i),
    .dma_fill_i (dma_fill_i),
    .tx_end_o   (tx_end_o)
);

// File: tb/sctx_end_flag_bench.sv
module sctx_end_flag_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic low_power_i = 0, tx_en_i = 0, err_sig_i = 0, gsm_i = 0, blk_i = 0;
    logic char_done_i = 0, half_tick_i = 0, empty_i = 0;
    logic empty_rd_i = 0, empty_wr0_i = 0, dma_fill_i = 0;
    logic tx_end_o;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    sctx_end_flag u_sctx_end_flag (.*);

    task automatic chk(input logic exp, input string req);
        n_chk++;
        if (tx_end_o !== exp) begin
            n_fail++;
            $display("FAIL %s: tx_end_o=%b expected %b", req, tx_end_o, exp);
        end
    endtask

    // one cycle with the given pulse already driven, then clear pulses
    task automatic step();
        @(posedge clk); @(negedge clk);
        char_done_i = 0; half_tick_i = 0; empty_rd_i = 0;
        empty_wr0_i = 0; dma_fill_i = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin half_tick_i = 1; step(); step(); end
    endtask

    // enable, clear the flag with a DMA fill, end a character
    task automatic arm_char(input logic g, input logic b);
        gsm_i = g; blk_i = b; tx_en_i = 1; err_sig_i = 0; empty_i = 1;
        dma_fill_i = 1; step();
        char_done_i = 1; step();
    endtask

    task automatic t_reset();
        chk(1'b1, "R1 in reset");
        rst_n = 1; step();
        chk(1'b1, "R1 after reset");
    endtask

    task automatic t_guard(input logic g, input logic b, input int n, input string req);
        arm_char(g, b);
        ticks(n - 1);
        chk(1'b0, {req, " before last tick"});
        ticks(1);
        chk(1'b1, {req, " after last tick"});
    endtask

    task automatic t_tick_with_start();
        arm_char(1, 0);
        char_done_i = 1; half_tick_i = 1; step();
        ticks(1);
        chk(1'b0, "R13 coincident tick not counted");
        ticks(1);
        chk(1'b1, "R13 set after two later ticks");
    endtask

    task automatic t_sw_clear();
        empty_i = 1; empty_rd_i = 1; step();
        empty_wr0_i = 1; step();
        chk(1'b0, "R7 read-as-1 then write 0 clears");
        char_done_i = 1; step(); ticks(2);
        chk(1'b1, "R7 flag set again by guard");
        empty_wr0_i = 1; step();
        chk(1'b1, "R9 write 0 without read ignored");
        empty_i = 0; empty_rd_i = 1; step();
        empty_i = 1; empty_wr0_i = 1; step();
        chk(1'b1, "R9 read while not empty does not qualify");
    endtask

    task automatic t_dma();
        tx_en_i = 1; empty_i = 1;
        dma_fill_i = 1; step();
        chk(1'b0, "R8 DMA fill clears");
    endtask

    task automatic t_err_abort();
        arm_char(0, 0);
        ticks(2);
        err_sig_i = 1; step();
        err_sig_i = 0; step();
        ticks(5);
        chk(1'b0, "R10 error cancels pending set");
        char_done_i = 1; step(); ticks(1);
        err_sig_i = 1; ticks(1);
        chk(1'b0, "R10 no set while error present");
        err_sig_i = 0; step();
    endtask

    task automatic t_refill_abort();
        arm_char(0, 1);
        ticks(1);
        dma_fill_i = 1; step();
        ticks(4);
        chk(1'b0, "R11 refill cancels pending set");
    endtask

    task automatic t_not_empty();
        arm_char(1, 1);
        empty_i = 0;
        ticks(2);
        chk(1'b0, "R12 no set while data pending");
        empty_i = 1;
    endtask

    task automatic t_idle();
        tx_en_i = 1; dma_fill_i = 1; step();
        tx_en_i = 0; err_sig_i = 1; step();
        chk(1'b0, "R3 disabled with error holds");
        err_sig_i = 0; step();
        chk(1'b1, "R3 disabled without error sets");
    endtask

    task automatic t_low_power();
        tx_en_i = 1; err_sig_i = 1; dma_fill_i = 1; step();
        low_power_i = 1; step();
        chk(1'b1, "R2 low power forces flag");
        low_power_i = 0; err_sig_i = 0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_guard(0, 0, 5, "R4");
        t_guard(0, 1, 3, "R5");
        t_guard(1, 0, 2, "R6 blk=0");
        t_guard(1, 1, 2, "R6 blk=1");
        t_tick_with_start();
        t_sw_clear();
        t_dma();
        t_err_abort();
        t_refill_abort();
        t_not_empty();
        t_idle();
        t_low_power();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule